// File: doc/BRIEF.md
# Multi-Channel UART Command and Flow-Character Register

This block sits between the host bus and the per-channel UART engines of an eight-channel serial controller. Each host write targets one channel and one of three registers: the command register, the Xon character register or the Xoff character register. A command write carries two enable bits, a lock bit and a 5-bit command code. The enable bits set the receiver and transmitter enable state of that channel unless the lock bit is set. The code is turned into a single-cycle strobe tagged with the channel number, and the serial, FIFO and status logic further down acts on that strobe.

The block also keeps the active-low RTS output of each channel and the per-channel Xon/Xoff flow-control characters. Four commands are global and are accepted only from channel 0. Two of them arm a one-shot broadcast, so that the next write to channel 0's Xon (or Xoff) register fills that register in every channel. The other two preload every channel's Xon register with 0x11 or every Xoff register with 0x13. A further global code, 11111 from channel 0, resets the whole block.

Top module: `uart_cmd_hub`

## Requirements
- R1: A write with `wr_sel_i` = 0 is a command write. In the data byte, bits 7:3 are the code, bit 2 is the lock, bit 1 is the transmitter enable and bit 0 is the receiver enable. With the lock at 0, the addressed channel's `tx_en_o`/`rx_en_o` bits take bits 1 and 0 in the cycle after the write.
- R2: When the lock bit is 1, bits 1:0 are ignored and both enable bits of the channel are kept.
- R3: Every accepted command other than code 00000 gives `cmd_vld_o` high for exactly one cycle, in the cycle after the write, with `cmd_ch_o` and `cmd_code_o`. Codes 00000, 00001, 01011, 01110, 01111, 11001, 11010, 11100 and 11101 give no strobe and have no effect beyond the enable bits.
- R4: Code 00010 clears the channel's receiver enable and code 00011 clears its transmitter enable. Both override the enable bits of the same write.
- R5: Code 01000 drives that channel's `rts_no` low and code 01001 drives it high. Other channels keep their RTS level.
- R6: A write with `wr_sel_i` = 1 (Xon) or 2 (Xoff) loads the data byte into that channel's character register only. Channel n's byte appears at bits 8n+7:8n of `xon_o` or `xoff_o`.
- R7: Code 10010 from channel 0 arms Xon broadcast. The next Xon write to channel 0 loads its byte into every channel and disarms the broadcast. Xon writes to other channels while armed stay individual and leave it armed. Code 10011 does the same for Xoff.
- R8: Code 10100 from channel 0 loads 0x11 into all Xon registers at once. Code 10101 loads 0x13 into all Xoff registers.
- R9: Codes 10010, 10011, 10100, 10101 and 11111 written to channels 1 to 7 have no effect and give no strobe.
- R10: Code 11111 from channel 0 is strobed. In the same cycle it clears all enables, sets all RTS outputs high, zeroes all character registers and disarms both broadcasts, whatever the lock bit is.
- R11: After reset, all enables are 0, all `rts_no` bits are 1, the character registers are 0, no strobe is present and both character banks are in individual write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write valid |
| wr_sel_i | input | 2 | Target register: 0 command, 1 Xon, 2 Xoff, 3 none |
| wr_ch_i | input | 3 | Target channel, 0 is the global channel |
| wr_data_i | input | 8 | Write data |
| rx_en_o | output | 8 | Receiver enable per channel |
| tx_en_o | output | 8 | Transmitter enable per channel |
| rts_no | output | 8 | RTS per channel, active low |
| cmd_vld_o | output | 1 | Command strobe, one cycle |
| cmd_ch_o | output | 3 | Channel of the strobed command |
| cmd_code_o | output | 5 | Code of the strobed command |
| xon_o | output | 64 | Xon characters, channel n at bits 8n+7:8n |
| xoff_o | output | 64 | Xoff characters, channel n at bits 8n+7:8n |

## Verification
The assertions check cycle-local rules on every cycle. A locked write keeps the enables. RTS, receiver-reset and preload commands land in the next cycle. Strobes follow only command writes, never carry a reserved code and carry a global code only from channel 0. A device reset leaves everything cleared, and an armed broadcast write disarms and fills every channel. The scenarios show what spans several writes and what can only be seen at the ports: the sequence arm, intervening individual write, broadcast, then individual again; and that global codes from other channels leave no trace. They also show that the exact strobe stream matches, with no missing or extra pulses, and that individual mode is back after a device reset.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;
  localparam int CODE_W = 5;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_XON  = 2'd1;
  localparam logic [1:0] SEL_XOFF = 2'd2;

  localparam logic [CODE_W-1:0] CMD_NOP     = 5'b00000;
  localparam logic [CODE_W-1:0] CMD_RST_RX  = 5'b00010;
  localparam logic [CODE_W-1:0] CMD_RST_TX  = 5'b00011;
  localparam logic [CODE_W-1:0] CMD_RTS_ON  = 5'b01000;
  localparam logic [CODE_W-1:0] CMD_RTS_OFF = 5'b01001;
  localparam logic [CODE_W-1:0] CMD_GW_XON  = 5'b10010;
  localparam logic [CODE_W-1:0] CMD_GW_XOFF = 5'b10011;
  localparam logic [CODE_W-1:0] CMD_GL_XON  = 5'b10100;
  localparam logic [CODE_W-1:0] CMD_GL_XOFF = 5'b10101;
  localparam logic [CODE_W-1:0] CMD_RST_DEV = 5'b11111;

  localparam logic [7:0] XON_DFLT  = 8'h11;
  localparam logic [7:0] XOFF_DFLT = 8'h13;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              lock;
    logic              tx;
    logic              rx;
  } cr_fields_t;

  function automatic logic cmd_reserved(input logic [CODE_W-1:0] c);
    case (c)
      5'b00001, 5'b01011, 5'b01110, 5'b01111,
      5'b11001, 5'b11010, 5'b11100, 5'b11101: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic cmd_global(input logic [CODE_W-1:0] c);
    case (c)
      CMD_GW_XON, CMD_GW_XOFF, CMD_GL_XON, CMD_GL_XOFF, CMD_RST_DEV: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_cmd_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [CH_W-1:0] wr_ch_i,
  input  logic [7:0]      wr_data_i,
  output logic            cmd_wr_o,
  output cr_fields_t      fld_o,
  output logic            accept_o,
  output logic            dev_rst_o,
  output logic            gw_xon_o,
  output logic            gw_xoff_o,
  output logic            gl_xon_o,
  output logic            gl_xoff_o
);
  logic from_a;

  assign fld_o    = cr_fields_t'(wr_data_i);
  assign cmd_wr_o = wr_en_i && (wr_sel_i == SEL_CMD);
  assign from_a   = (wr_ch_i == '0);

  // global codes only count when written through channel 0
  assign accept_o = cmd_wr_o && (fld_o.code != CMD_NOP) && !cmd_reserved(fld_o.code)
                    && (!cmd_global(fld_o.code) || from_a);

  assign dev_rst_o = accept_o && (fld_o.code == CMD_RST_DEV);
  assign gw_xon_o  = accept_o && (fld_o.code == CMD_GW_XON);
  assign gw_xoff_o = accept_o && (fld_o.code == CMD_GW_XOFF);
  assign gl_xon_o  = accept_o && (fld_o.code == CMD_GL_XON);
  assign gl_xoff_o = accept_o && (fld_o.code == CMD_GL_XOFF);
endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
  import uart_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       dev_rst_i,
  input  cr_fields_t fld_i,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       rts_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_o <= 1'b0;
      tx_en_o <= 1'b0;
      rts_n_o <= 1'b1;
    end else if (dev_rst_i) begin
      rx_en_o <= 1'b0;
      tx_en_o <= 1'b0;
      rts_n_o <= 1'b1;
    end else if (hit_i) begin
      if (fld_i.code == CMD_RST_RX) rx_en_o <= 1'b0;
      else if (!fld_i.lock)         rx_en_o <= fld_i.rx;

      if (fld_i.code == CMD_RST_TX) tx_en_o <= 1'b0;
      else if (!fld_i.lock)         tx_en_o <= fld_i.tx;

      if (fld_i.code == CMD_RTS_ON)       rts_n_o <= 1'b0;
      else if (fld_i.code == CMD_RTS_OFF) rts_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_xchar_bank.sv
module uart_xchar_bank #(
  parameter int         NCH  = 8,
  parameter int         CH_W = 3,
  parameter logic [7:0] DFLT = 8'h11,
  localparam int        XW   = NCH * 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dev_rst_i,
  input  logic            wr_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic [7:0]      data_i,
  input  logic            arm_i,
  input  logic            load_i,
  output logic [XW-1:0]   chars_o,
  output logic            armed_o
);
  logic gang_hit;

  assign gang_hit = wr_i && armed_o && (ch_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_o <= 1'b0;
    else if (dev_rst_i) armed_o <= 1'b0;
    else if (arm_i)     armed_o <= 1'b1;
    else if (gang_hit)  armed_o <= 1'b0;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          chars_o[g*8 +: 8] <= '0;
      else if (dev_rst_i)                   chars_o[g*8 +: 8] <= '0;
      else if (load_i)                      chars_o[g*8 +: 8] <= DFLT;
      else if (gang_hit)                    chars_o[g*8 +: 8] <= data_i;
      else if (wr_i && ch_i == CH_W'(g))    chars_o[g*8 +: 8] <= data_i;
    end
  end
endmodule

// File: rtl/uart_cmd_hub.sv
module uart_cmd_hub
  import uart_cmd_pkg::*;
#(
  parameter int  NCH  = 8,
  localparam int CH_W = $clog2(NCH),
  localparam int XW   = NCH * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [7:0]        wr_data_i,
  output logic [NCH-1:0]    rx_en_o,
  output logic [NCH-1:0]    tx_en_o,
  output logic [NCH-1:0]    rts_no,
  output logic              cmd_vld_o,
  output logic [CH_W-1:0]   cmd_ch_o,
  output logic [CODE_W-1:0] cmd_code_o,
  output logic [XW-1:0]     xon_o,
  output logic [XW-1:0]     xoff_o
);
  logic       cmd_wr, accept, dev_rst;
  logic       gw_xon, gw_xoff, gl_xon, gl_xoff;
  logic       gang_xon, gang_xoff;
  cr_fields_t fld;

  uart_cmd_decode #(.CH_W(CH_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_ch_i   (wr_ch_i),
    .wr_data_i (wr_data_i),
    .cmd_wr_o  (cmd_wr),
    .fld_o     (fld),
    .accept_o  (accept),
    .dev_rst_o (dev_rst),
    .gw_xon_o  (gw_xon),
    .gw_xoff_o (gw_xoff),
    .gl_xon_o  (gl_xon),
    .gl_xoff_o (gl_xoff)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    uart_chan_ctrl u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (cmd_wr && wr_ch_i == CH_W'(c)),
      .dev_rst_i (dev_rst),
      .fld_i     (fld),
      .rx_en_o   (rx_en_o[c]),
      .tx_en_o   (tx_en_o[c]),
      .rts_n_o   (rts_no[c])
    );
  end

  uart_xchar_bank #(.NCH(NCH), .CH_W(CH_W), .DFLT(XON_DFLT)) u_xon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dev_rst_i (dev_rst),
    .wr_i      (wr_en_i && wr_sel_i == SEL_XON),
    .ch_i      (wr_ch_i),
    .data_i    (wr_data_i),
    .arm_i     (gw_xon),
    .load_i    (gl_xon),
    .chars_o   (xon_o),
    .armed_o   (gang_xon)
  );

  uart_xchar_bank #(.NCH(NCH), .CH_W(CH_W), .DFLT(XOFF_DFLT)) u_xoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dev_rst_i (dev_rst),
    .wr_i      (wr_en_i && wr_sel_i == SEL_XOFF),
    .ch_i      (wr_ch_i),
    .data_i    (wr_data_i),
    .arm_i     (gw_xoff),
    .load_i    (gl_xoff),
    .chars_o   (xoff_o),
    .armed_o   (gang_xoff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_o  <= 1'b0;
      cmd_ch_o   <= '0;
      cmd_code_o <= '0;
    end else begin
      cmd_vld_o <= accept;
      if (accept) begin
        cmd_ch_o   <= wr_ch_i;
        cmd_code_o <= fld.code;
      end
    end
  end
endmodule

// File: rtl/uart_cmd_hub_chk.sv
module uart_cmd_hub_chk
  import uart_cmd_pkg::*;
#(
  parameter int  NCH  = 8,
  localparam int CH_W = $clog2(NCH),
  localparam int XW   = NCH * 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [CH_W-1:0]   wr_ch_i,
  input logic [7:0]        wr_data_i,
  input logic [NCH-1:0]    rx_en_o,
  input logic [NCH-1:0]    tx_en_o,
  input logic [NCH-1:0]    rts_no,
  input logic              cmd_vld_o,
  input logic [CH_W-1:0]   cmd_ch_o,
  input logic [CODE_W-1:0] cmd_code_o,
  input logic [XW-1:0]     xon_o,
  input logic [XW-1:0]     xoff_o,
  input logic              gang_xon,
  input logic              gang_xoff
);
  function automatic logic all_eq(input logic [XW-1:0] v, input logic [7:0] b);
    for (int i = 0; i < NCH; i++) if (v[i*8 +: 8] != b) return 1'b0;
    return 1'b1;
  endfunction

  logic              cw;
  logic [CODE_W-1:0] wc;
  assign cw = wr_en_i && (wr_sel_i == SEL_CMD);
  assign wc = wr_data_i[7:3];

  AST_LOCK_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw && wr_data_i[2] && wc != CMD_RST_RX && wc != CMD_RST_TX && wc != CMD_RST_DEV
    |=> rx_en_o == $past(rx_en_o) && tx_en_o == $past(tx_en_o)); // R2
  AST_RST_RX_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw && wc == CMD_RST_RX |=> !rx_en_o[$past(wr_ch_i)]); // R4
  AST_RTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw && wc == CMD_RTS_ON |=> !rts_no[$past(wr_ch_i)]); // R5
  AST_RTS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw && wc == CMD_RTS_OFF |=> rts_no[$past(wr_ch_i)]); // R5
  AST_STROBE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cw |=> !cmd_vld_o); // R3
  AST_STROBE_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> !cmd_reserved(cmd_code_o) && cmd_code_o != CMD_NOP); // R3
  AST_GLOBAL_FROM_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o && cmd_global(cmd_code_o) |-> cmd_ch_o == '0); // R9
  AST_GANG_LOAD_XON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw && wr_ch_i == '0 && wc == CMD_GL_XON |=> all_eq(xon_o, XON_DFLT)); // R8
  AST_GANG_LOAD_XOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw && wr_ch_i == '0 && wc == CMD_GL_XOFF |=> all_eq(xoff_o, XOFF_DFLT)); // R8
  AST_GANG_WRITE_XON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gang_xon && wr_en_i && wr_sel_i == SEL_XON && wr_ch_i == '0
    |=> !gang_xon && all_eq(xon_o, $past(wr_data_i))); // R7
  AST_DEV_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o && cmd_code_o == CMD_RST_DEV
    |-> rx_en_o == '0 && tx_en_o == '0 && (&rts_no) && !gang_xon && !gang_xoff); // R10
endmodule

bind uart_cmd_hub uart_cmd_hub_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/uart_cmd_hub_tb.sv
module uart_cmd_hub_tb;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [2:0]  wr_ch = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rx_en, tx_en, rts_n;
  logic        cmd_vld;
  logic [2:0]  cmd_ch;
  logic [4:0]  cmd_code;
  logic [63:0] xon, xoff;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];

  always #(CLK_P / 2) clk = ~clk;

  uart_cmd_hub u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_ch_i(wr_ch), .wr_data_i(wr_data), .rx_en_o(rx_en), .tx_en_o(tx_en),
    .rts_no(rts_n), .cmd_vld_o(cmd_vld), .cmd_ch_o(cmd_ch), .cmd_code_o(cmd_code),
    .xon_o(xon), .xoff_o(xoff)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3/R9: which writes must produce a strobe
  function automatic logic strobe_due(input logic [2:0] ch, input logic [4:0] c);
    logic rsv, glb;
    rsv = c inside {5'b00000, 5'b00001, 5'b01011, 5'b01110, 5'b01111,
                    5'b11001, 5'b11010, 5'b11100, 5'b11101};
    glb = c inside {5'b10010, 5'b10011, 5'b10100, 5'b10101, 5'b11111};
    return !rsv && (!glb || ch == 3'd0);
  endfunction

  function automatic logic [7:0] cr(input logic [4:0] c, input logic lk, input logic t, input logic r);
    return {c, lk, t, r};
  endfunction

  // driver: pushes expected strobes into the scoreboard queue
  task automatic wr(input logic [1:0] sel, input logic [2:0] ch, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_ch = ch; wr_data = d;
    if (sel == 2'd0 && strobe_due(ch, d[7:3])) exp_q.push_back({ch, d[7:3]});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: pops and compares every strobe
  always @(negedge clk) begin
    if (rst_n && cmd_vld) begin
      if (exp_q.size() == 0) check("R3 unexpected strobe", {56'd0, cmd_ch, cmd_code}, 64'hFFFF);
      else check("R3 strobe ch/code", {56'd0, cmd_ch, cmd_code}, {56'd0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 rx_en reset", rx_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 rx_en", rx_en, 0);
    check("R11 tx_en", tx_en, 0);
    check("R11 rts high", rts_n, 8'hFF);
    check("R11 xon zero", xon, 0);
    check("R11 xoff zero", xoff, 0);
    check("R11 no strobe", cmd_vld, 0);

    wr(0, 3, cr(5'b00000, 0, 1, 1));
    check("R1 rx_en ch3", rx_en, 8'h08);
    check("R1 tx_en ch3", tx_en, 8'h08);
    wr(0, 5, cr(5'b00000, 0, 1, 0));
    check("R1 rx_en ch5 off", rx_en, 8'h08);
    check("R1 tx_en ch5 on", tx_en, 8'h28);

    wr(0, 3, cr(5'b01000, 1, 0, 0));
    check("R2 lock rx kept", rx_en, 8'h08);
    check("R2 lock tx kept", tx_en, 8'h28);
    check("R5 rts ch3 low", rts_n, 8'hF7);
    wr(0, 3, cr(5'b01001, 1, 0, 0));
    check("R5 rts ch3 high", rts_n, 8'hFF);

    wr(0, 3, cr(5'b00010, 0, 1, 1));
    check("R4 reset rx overrides bit0", rx_en, 8'h00);
    check("R4 tx follows bit1", tx_en, 8'h28);
    wr(0, 5, cr(5'b00011, 1, 0, 0));
    check("R4 reset tx ch5", tx_en, 8'h08);

    wr(0, 2, cr(5'b00001, 0, 1, 1));
    check("R3 reserved no strobe", cmd_vld, 0);
    check("R3 reserved enables rx", rx_en, 8'h04);
    check("R3 reserved enables tx", tx_en, 8'h0C);
    wr(0, 2, cr(5'b01110, 1, 0, 0));
    check("R3 reserved no strobe 01110", cmd_vld, 0);
    check("R3 reserved rts unchanged", rts_n, 8'hFF);

    wr(1, 4, 8'h5A);
    check("R6 xon ch4", xon, 64'h0000_005A_0000_0000);
    wr(2, 1, 8'hA5);
    check("R6 xoff ch1", xoff, 64'h0000_0000_0000_A500);

    wr(0, 6, cr(5'b10100, 1, 0, 0));
    check("R9 gang load from ch6 ignored", xon, 64'h0000_005A_0000_0000);
    wr(0, 6, cr(5'b11111, 1, 0, 0));
    check("R9 dev reset from ch6 ignored rx", rx_en, 8'h04);
    check("R9 dev reset from ch6 ignored xoff", xoff, 64'h0000_0000_0000_A500);
    wr(0, 6, cr(5'b10010, 1, 0, 0));
    wr(1, 0, 8'h66);
    check("R9 gang arm from ch6 ignored", xon, 64'h0000_005A_0000_0066);

    wr(0, 0, cr(5'b10100, 1, 0, 0));
    check("R8 gang load xon", xon, {8{8'h11}});
    wr(0, 0, cr(5'b10101, 1, 0, 0));
    check("R8 gang load xoff", xoff, {8{8'h13}});

    wr(0, 0, cr(5'b10010, 1, 0, 0));
    wr(1, 2, 8'h77);
    check("R7 armed write to ch2 stays individual", xon, 64'h1111_1111_1177_1111);
    wr(1, 0, 8'h42);
    check("R7 broadcast xon", xon, {8{8'h42}});
    wr(1, 0, 8'h99);
    check("R7 back to individual", xon, 64'h4242_4242_4242_4299);
    wr(0, 0, cr(5'b10011, 1, 0, 0));
    wr(2, 0, 8'h3C);
    check("R7 broadcast xoff", xoff, {8{8'h3C}});
    check("R7 xon untouched by xoff gang", xon, 64'h4242_4242_4242_4299);

    wr(0, 7, cr(5'b10000, 1, 0, 0));
    wr(0, 1, cr(5'b11011, 1, 0, 0));
    check("R3 strobed commands keep enables", rx_en, 8'h04);

    wr(0, 0, cr(5'b10010, 1, 0, 0));
    wr(0, 1, cr(5'b01000, 1, 0, 0));
    check("R5 rts ch1 low", rts_n, 8'hFD);
    wr(0, 0, cr(5'b11111, 1, 1, 1));
    check("R10 rx cleared", rx_en, 0);
    check("R10 tx cleared", tx_en, 0);
    check("R10 rts high", rts_n, 8'hFF);
    check("R10 xon zero", xon, 0);
    check("R10 xoff zero", xoff, 0);
    wr(1, 0, 8'h10);
    check("R11 individual mode after device reset", xon, 64'h10);

    repeat (2) @(negedge clk);
    check("R3 all strobes seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule